// File: doc/BRIEF.md
# Dual-Clock Host Byte Mailbox

This block joins a byte-wide host bus to a processor that runs on its own clock. It carries one word at a time in each direction. To send a word, the host writes a high byte and then a low byte. The low-byte write commits the word. The word then crosses into the processor clock domain and lands in a processor receive register. In the other direction, the processor loads a whole word. The host reads that word back as two bytes, and reading the low byte ends the read.

Each direction has an empty flag on its sending side and a full flag on its receiving side. Each flag is driven from the clock domain of the side that reads it. An event crosses between domains as a toggle that passes through a two-flop synchronizer. This way a load or a take is seen once, exactly once. A sender that loads while its empty flag is clear may corrupt the word in flight. Such a load never creates a second transfer.

Top module: `hbm_mailbox`

## Requirements
- R1: After reset, `hst_tx_empty` and `cpu_tx_empty` are 1. `hst_rx_full` and `cpu_rx_full` are 0. `cpu_rx_data` is 0, and `hst_rdata` is 0 for either byte select.
- R2: `hst_sel` = 1 selects the high byte and `hst_sel` = 0 selects the low byte. A host write of the high byte alone starts no transfer: `cpu_rx_full` stays 0 and `hst_tx_empty` stays 1.
- R3: A host write of the low byte while `hst_tx_empty` = 1 clears `hst_tx_empty` on that host edge. Within 8 `cpu_clk` cycles, `cpu_rx_full` rises and `cpu_rx_data` holds {high byte, low byte}.
- R4: While `cpu_rx_full` = 1, `cpu_rx_data` holds steady and `hst_tx_empty` stays 0. A `cpu_rx_rd` pulse clears `cpu_rx_full` on that edge, and `hst_tx_empty` returns to 1 within 8 `hst_clk` cycles.
- R5: A `cpu_tx_wr` pulse while `cpu_tx_empty` = 1 clears `cpu_tx_empty` on that edge. Within 8 `hst_clk` cycles, `hst_rx_full` rises, and the word's high and low bytes are readable with `hst_sel` = 1 and 0.
- R6: A host read of the high byte leaves `hst_rx_full` set. A host read of the low byte clears `hst_rx_full` on that edge, and `cpu_tx_empty` returns to 1 within 8 `cpu_clk` cycles.
- R7: A host low-byte write while `hst_tx_empty` = 0 produces no second transfer. After the one word is taken, `cpu_rx_full` stays 0.
- R8: A `cpu_tx_wr` while `cpu_tx_empty` = 0 produces no second transfer. After the host reads the one word, `hst_rx_full` stays 0.
- R9: A `cpu_rx_rd` while `cpu_rx_full` = 0 has no effect. A later host word keeps `hst_tx_empty` at 0 until a real take. A host low-byte read while `hst_rx_full` = 0 likewise leaves a later `cpu_tx_empty` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hst_clk | input | 1 | Host-side clock |
| hst_rst | input | 1 | Host-side synchronous reset, active high |
| hst_wr | input | 1 | Host write strobe |
| hst_rd | input | 1 | Host read strobe |
| hst_sel | input | 1 | Byte select: 1 = high, 0 = low |
| hst_wdata | input | 8 | Host write byte |
| hst_rdata | output | 8 | Selected received byte |
| hst_tx_empty | output | 1 | Host transmit bytes may be written |
| hst_rx_full | output | 1 | Host receive bytes hold a word |
| cpu_clk | input | 1 | Processor clock |
| cpu_rst | input | 1 | Processor-side synchronous reset, active high |
| cpu_tx_wr | input | 1 | Processor word load strobe |
| cpu_tx_data | input | 16 | Processor word to send |
| cpu_tx_empty | output | 1 | Processor transmit register free |
| cpu_rx_rd | input | 1 | Processor take strobe |
| cpu_rx_data | output | 16 | Word received from the host |
| cpu_rx_full | output | 1 | Processor receive register holds a word |

## Verification
A lost toggle in either lane leaves a flag stuck. The host would see `hst_tx_empty` stay 0, or the processor would see `cpu_tx_empty` stay 0, once the 8-cycle return window is over. A doubled toggle shows up in a different way: a full flag rises again after a take, within a few cycles of that take. A bad capture register or a bad byte mux shows as a wrong `cpu_rx_data` or `hst_rdata` value in the first cycle after the full flag rises.

// File: rtl/hbm_pkg.sv
package hbm_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int SYNC_STAGES = 2;

    typedef enum logic {
        SEL_LO = 1'b0,
        SEL_HI = 1'b1
    } hbm_sel_e;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } hbm_word_t;

    function automatic hbm_word_t join_bytes(input logic [BYTE_W-1:0] hi,
                                             input logic [BYTE_W-1:0] lo);
        hbm_word_t w;
        w.hi = hi;
        w.lo = lo;
        return w;
    endfunction
endpackage

// File: rtl/hbm_sync.sv
module hbm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hbm_lane.sv
module hbm_lane #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         src_clk,
    input  logic         src_rst,
    input  logic         src_ld,
    input  logic [W-1:0] src_data,
    output logic         src_empty,
    input  logic         dst_clk,
    input  logic         dst_rst,
    input  logic         dst_take,
    output logic [W-1:0] dst_data,
    output logic         dst_full
);
    // source domain
    logic [W-1:0] hold_q;
    logic         empty_q, req_t, ack_s, ack_seen, ack_edge;
    // destination domain
    logic [W-1:0] cap_q;
    logic         full_q, ack_t, req_s, req_seen, req_edge;

    hbm_sync #(.STAGES(STAGES)) u_req_sync (
        .clk(dst_clk), .rst(dst_rst), .d(req_t), .q(req_s));
    hbm_sync #(.STAGES(STAGES)) u_ack_sync (
        .clk(src_clk), .rst(src_rst), .d(ack_t), .q(ack_s));

    assign ack_edge = ack_s ^ ack_seen;
    assign req_edge = req_s ^ req_seen;

    always_ff @(posedge src_clk) begin
        if (src_rst) begin
            hold_q   <= '0;
            empty_q  <= 1'b1;
            req_t    <= 1'b0;
            ack_seen <= 1'b0;
        end else begin
            ack_seen <= ack_s;
            if (src_ld) hold_q <= src_data;   // late load may corrupt, by contract
            if (src_ld && empty_q) begin
                empty_q <= 1'b0;
                req_t   <= ~req_t;
            end else if (ack_edge) begin
                empty_q <= 1'b1;
            end
        end
    end

    always_ff @(posedge dst_clk) begin
        if (dst_rst) begin
            cap_q    <= '0;
            full_q   <= 1'b0;
            ack_t    <= 1'b0;
            req_seen <= 1'b0;
        end else begin
            req_seen <= req_s;
            if (req_edge) begin
                cap_q  <= hold_q;
                full_q <= 1'b1;
            end else if (dst_take && full_q) begin
                full_q <= 1'b0;
                ack_t  <= ~ack_t;
            end
        end
    end

    assign src_empty = empty_q;
    assign dst_data  = cap_q;
    assign dst_full  = full_q;

    // R3 (and R5 on the return lane): an accepted load drops empty
    p_load_clears_empty_r3: assert property (@(posedge src_clk) disable iff (src_rst)
        (src_ld && src_empty) |=> !src_empty);
    // R4 (and R6): a take of a held word drops full
    p_take_clears_full_r4: assert property (@(posedge dst_clk) disable iff (dst_rst)
        (dst_take && dst_full) |=> !dst_full);
    // R7/R8: full only rises on a synchronized request edge
    p_full_needs_req_r7: assert property (@(posedge dst_clk) disable iff (dst_rst)
        $rose(dst_full) |-> $past(req_edge));
    // R9: empty only returns on a synchronized acknowledge edge
    p_empty_needs_ack_r9: assert property (@(posedge src_clk) disable iff (src_rst)
        $rose(src_empty) |-> $past(ack_edge));
    // R4: received word holds while full
    p_data_holds_r4: assert property (@(posedge dst_clk) disable iff (dst_rst)
        (dst_full && $past(dst_full)) |-> $stable(dst_data));
endmodule

// File: rtl/hbm_host_port.sv
module hbm_host_port
    import hbm_pkg::*;
(
    input  logic              hst_clk,
    input  logic              hst_rst,
    input  logic              hst_wr,
    input  logic              hst_rd,
    input  logic              hst_sel,
    input  logic [BYTE_W-1:0] hst_wdata,
    input  logic [WORD_W-1:0] rx_word,
    output logic              tx_ld,
    output logic [WORD_W-1:0] tx_word,
    output logic              rx_take,
    output logic [BYTE_W-1:0] hst_rdata
);
    hbm_sel_e          sel;
    hbm_word_t         rx_w;
    logic [BYTE_W-1:0] tx_hi_q;

    assign sel  = hbm_sel_e'(hst_sel);
    assign rx_w = hbm_word_t'(rx_word);

    always_ff @(posedge hst_clk) begin
        if (hst_rst)                        tx_hi_q <= '0;
        else if (hst_wr && sel == SEL_HI)   tx_hi_q <= hst_wdata;
    end

    assign tx_ld     = hst_wr && (sel == SEL_LO);
    assign tx_word   = join_bytes(tx_hi_q, hst_wdata);
    assign rx_take   = hst_rd && (sel == SEL_LO);
    assign hst_rdata = (sel == SEL_HI) ? rx_w.hi : rx_w.lo;
endmodule

// File: rtl/hbm_mailbox.sv
module hbm_mailbox
    import hbm_pkg::*;
(
    input  logic              hst_clk,
    input  logic              hst_rst,
    input  logic              hst_wr,
    input  logic              hst_rd,
    input  logic              hst_sel,
    input  logic [BYTE_W-1:0] hst_wdata,
    output logic [BYTE_W-1:0] hst_rdata,
    output logic              hst_tx_empty,
    output logic              hst_rx_full,
    input  logic              cpu_clk,
    input  logic              cpu_rst,
    input  logic              cpu_tx_wr,
    input  logic [WORD_W-1:0] cpu_tx_data,
    output logic              cpu_tx_empty,
    input  logic              cpu_rx_rd,
    output logic [WORD_W-1:0] cpu_rx_data,
    output logic              cpu_rx_full
);
    logic              tx_ld, rx_take;
    logic [WORD_W-1:0] tx_word, rx_word;

    hbm_host_port u_port (
        .hst_clk(hst_clk), .hst_rst(hst_rst), .hst_wr(hst_wr), .hst_rd(hst_rd),
        .hst_sel(hst_sel), .hst_wdata(hst_wdata), .rx_word(rx_word),
        .tx_ld(tx_ld), .tx_word(tx_word), .rx_take(rx_take), .hst_rdata(hst_rdata));

    // host to processor
    hbm_lane #(.W(WORD_W), .STAGES(SYNC_STAGES)) u_h2c (
        .src_clk(hst_clk), .src_rst(hst_rst), .src_ld(tx_ld), .src_data(tx_word),
        .src_empty(hst_tx_empty),
        .dst_clk(cpu_clk), .dst_rst(cpu_rst), .dst_take(cpu_rx_rd),
        .dst_data(cpu_rx_data), .dst_full(cpu_rx_full));

    // processor to host
    hbm_lane #(.W(WORD_W), .STAGES(SYNC_STAGES)) u_c2h (
        .src_clk(cpu_clk), .src_rst(cpu_rst), .src_ld(cpu_tx_wr), .src_data(cpu_tx_data),
        .src_empty(cpu_tx_empty),
        .dst_clk(hst_clk), .dst_rst(hst_rst), .dst_take(rx_take),
        .dst_data(rx_word), .dst_full(hst_rx_full));
endmodule

// File: tb/hbm_mailbox_test.sv
module hbm_mailbox_test;
    localparam int HST_PERIOD = 10;
    localparam int CPU_PERIOD = 14;
    localparam int WAIT_LIM   = 8;
    localparam logic [31:0] VEC [0:3] = '{32'hA55A_0001, 32'h0000_FFFF,
                                          32'hFFFF_0000, 32'h1234_8CE7};

    logic hst_clk = 0, cpu_clk = 0, hst_rst = 1, cpu_rst = 1;
    logic hst_wr = 0, hst_rd = 0, hst_sel = 0;
    logic [7:0] hst_wdata = '0, hst_rdata;
    logic hst_tx_empty, hst_rx_full, cpu_tx_empty, cpu_rx_full;
    logic cpu_tx_wr = 0, cpu_rx_rd = 0;
    logic [15:0] cpu_tx_data = '0, cpu_rx_data;
    int checks = 0, failures = 0;
    logic [7:0] rb;

    always #(HST_PERIOD/2) hst_clk = ~hst_clk;
    always #(CPU_PERIOD/2) cpu_clk = ~cpu_clk;

    hbm_mailbox uut (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic host_wr(input logic s, input logic [7:0] d);
        @(negedge hst_clk); hst_wr = 1; hst_sel = s; hst_wdata = d;
        @(negedge hst_clk); hst_wr = 0;
    endtask

    task automatic host_rd(input logic s, output logic [7:0] d);
        @(negedge hst_clk); hst_rd = 1; hst_sel = s; #1 d = hst_rdata;
        @(negedge hst_clk); hst_rd = 0;
    endtask

    task automatic cpu_put(input logic [15:0] d);
        @(negedge cpu_clk); cpu_tx_wr = 1; cpu_tx_data = d;
        @(negedge cpu_clk); cpu_tx_wr = 0;
    endtask

    task automatic cpu_take();
        @(negedge cpu_clk); cpu_rx_rd = 1;
        @(negedge cpu_clk); cpu_rx_rd = 0;
    endtask

    task automatic wait_cpu_full();
        for (int i = 0; i < WAIT_LIM && !cpu_rx_full; i++) @(negedge cpu_clk);
    endtask
    task automatic wait_cpu_empty();
        for (int i = 0; i < WAIT_LIM && !cpu_tx_empty; i++) @(negedge cpu_clk);
    endtask
    task automatic wait_hst_full();
        for (int i = 0; i < WAIT_LIM && !hst_rx_full; i++) @(negedge hst_clk);
    endtask
    task automatic wait_hst_empty();
        for (int i = 0; i < WAIT_LIM && !hst_tx_empty; i++) @(negedge hst_clk);
    endtask
    task automatic idle_cpu(input int n);
        for (int i = 0; i < n; i++) @(negedge cpu_clk);
    endtask

    initial begin
        #(HST_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (6) @(negedge cpu_clk);
        hst_rst = 0; cpu_rst = 0;
        @(negedge hst_clk); #1;
        // R1 reset state
        chk(hst_tx_empty == 1, "R1", "hst_tx_empty", hst_tx_empty, 1);
        chk(cpu_tx_empty == 1, "R1", "cpu_tx_empty", cpu_tx_empty, 1);
        chk(hst_rx_full == 0, "R1", "hst_rx_full", hst_rx_full, 0);
        chk(cpu_rx_full == 0, "R1", "cpu_rx_full", cpu_rx_full, 0);
        chk(cpu_rx_data == 0, "R1", "cpu_rx_data", cpu_rx_data, 0);
        hst_sel = 1; #1;
        chk(hst_rdata == 0, "R1", "hst_rdata hi", hst_rdata, 0);
        hst_sel = 0; #1;
        chk(hst_rdata == 0, "R1", "hst_rdata lo", hst_rdata, 0);

        // vector table: {host word, processor word}
        for (int v = 0; v < 4; v++) begin
            logic [15:0] hw, cw;
            hw = VEC[v][31:16]; cw = VEC[v][15:0];
            host_wr(1'b1, hw[15:8]);
            host_wr(1'b0, hw[7:0]);
            chk(hst_tx_empty == 0, "R3", "hst_tx_empty after low write", hst_tx_empty, 0);
            wait_cpu_full();
            chk(cpu_rx_full == 1, "R3", "cpu_rx_full", cpu_rx_full, 1);
            idle_cpu(3);
            chk(cpu_rx_data == hw, "R3", "cpu_rx_data", cpu_rx_data, hw);
            chk(hst_tx_empty == 0, "R4", "hst_tx_empty before take", hst_tx_empty, 0);
            cpu_take();
            chk(cpu_rx_full == 0, "R4", "cpu_rx_full after take", cpu_rx_full, 0);
            wait_hst_empty();
            chk(hst_tx_empty == 1, "R4", "hst_tx_empty returns", hst_tx_empty, 1);

            cpu_put(cw);
            chk(cpu_tx_empty == 0, "R5", "cpu_tx_empty after load", cpu_tx_empty, 0);
            wait_hst_full();
            chk(hst_rx_full == 1, "R5", "hst_rx_full", hst_rx_full, 1);
            host_rd(1'b1, rb);
            chk(rb == cw[15:8], "R5", "high byte", rb, cw[15:8]);
            chk(hst_rx_full == 1, "R6", "hst_rx_full after high read", hst_rx_full, 1);
            host_rd(1'b0, rb);
            chk(rb == cw[7:0], "R5", "low byte", rb, cw[7:0]);
            chk(hst_rx_full == 0, "R6", "hst_rx_full after low read", hst_rx_full, 0);
            wait_cpu_empty();
            chk(cpu_tx_empty == 1, "R6", "cpu_tx_empty returns", cpu_tx_empty, 1);
        end

        // R2: high byte alone starts nothing
        host_wr(1'b1, 8'h5A);
        idle_cpu(20);
        chk(cpu_rx_full == 0, "R2", "cpu_rx_full after high only", cpu_rx_full, 0);
        chk(hst_tx_empty == 1, "R2", "hst_tx_empty after high only", hst_tx_empty, 1);
        host_wr(1'b0, 8'hC3);
        wait_cpu_full(); idle_cpu(1);
        chk(cpu_rx_data == 16'h5AC3, "R2", "joined word", cpu_rx_data, 16'h5AC3);
        cpu_take(); wait_hst_empty();

        // R7: extra low write while not empty
        host_wr(1'b1, 8'h11); host_wr(1'b0, 8'h22); host_wr(1'b0, 8'h33);
        wait_cpu_full();
        chk(cpu_rx_full == 1, "R7", "first transfer", cpu_rx_full, 1);
        cpu_take(); idle_cpu(20);
        chk(cpu_rx_full == 0, "R7", "no second transfer", cpu_rx_full, 0);
        wait_hst_empty();
        chk(hst_tx_empty == 1, "R7", "hst_tx_empty returns", hst_tx_empty, 1);

        // R8: extra processor load while not empty
        cpu_put(16'hBEEF); cpu_put(16'hD00D);
        wait_hst_full();
        chk(hst_rx_full == 1, "R8", "first transfer", hst_rx_full, 1);
        host_rd(1'b0, rb); idle_cpu(20);
        chk(hst_rx_full == 0, "R8", "no second transfer", hst_rx_full, 0);
        wait_cpu_empty();
        chk(cpu_tx_empty == 1, "R8", "cpu_tx_empty returns", cpu_tx_empty, 1);

        // R9: takes while nothing is held are ignored
        cpu_take(); cpu_take(); cpu_take();
        host_wr(1'b1, 8'h77); host_wr(1'b0, 8'h88);
        idle_cpu(20);
        chk(hst_tx_empty == 0, "R9", "hst_tx_empty held without take", hst_tx_empty, 0);
        chk(cpu_rx_data == 16'h7788, "R9", "word after stray takes", cpu_rx_data, 16'h7788);
        cpu_take(); wait_hst_empty();
        host_rd(1'b0, rb); host_rd(1'b0, rb); host_rd(1'b0, rb);
        cpu_put(16'h4242);
        idle_cpu(20);
        chk(cpu_tx_empty == 0, "R9", "cpu_tx_empty held without read", cpu_tx_empty, 0);
        chk(hst_rx_full == 1, "R9", "hst_rx_full after stray reads", hst_rx_full, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule